// File: doc/BRIEF.md
# Audio Interface Master Clock Generator

This block produces the bit clock and the left/right frame clock of a serial audio port from one fast core clock. The system clock is not a real clock here: it arrives as a stream of single-cycle tick enables, one stream from an external master clock and one from a PLL. A select bit picks one stream combinationally. Every counter in the block advances only on a selected tick, so the block never switches or divides a physical clock.

In master mode the block drives both audio clocks. The bit clock is the system clock divided by a power of two, chosen by a 3-bit code. The frame clock has a period of 128 system ticks times a scaling factor picked by a second 3-bit code, and that factor includes the half steps 1.5, 3, 6 and 12. Both clocks come from the same tick stream. Each frame boundary falls on a falling edge of the bit clock. A code change takes effect only at the next frame start, so no frame is ever cut short or stretched. In slave mode the output enables are low and all counters rest at zero. The first frame after entering master mode is a full frame long.

Top module: `aud_clkgen`

## Requirements
- R1: All timing counts selected ticks: `src_pll_sel` = 1 uses `pll_tick` and 0 uses `ext_tick`. In master mode, a cycle with no selected tick leaves `lrc_o` unchanged, and every period scales with the interval between ticks.
- R2: While `mode_master` is 0, `bclk_o` and `lrc_o` are 0 from the next cycle on, and both enables are 0.
- R3: While `mode_master` is 1, `bclk_oe` and `lrc_oe` are both 1.
- R4: Bit-clock code 000/001/010/011/100/101 gives a `bclk_o` period of 1/2/4/8/16/32 ticks. For ratios of 2 and up, `bclk_o` is low for the first half of each period and high for the second half. For ratio 1, `bclk_o` repeats the selected tick one cycle later.
- R5: Bit-clock codes 110 and 111 act as ratio 32.
- R6: `cfg_err` goes to 1 when a reserved bit-clock code is adopted. It stays at 1 until reset.
- R7: Frame-scale code 000..111 gives an `lrc_o` period of 128, 192, 256, 384, 512, 768, 1024 or 1536 ticks.
- R8: `lrc_o` rises at each frame start, stays high for exactly half the frame and is low for the other half.
- R9: With a bit-clock ratio of 2 or more, every `lrc_o` edge occurs in the same cycle as a falling edge of `bclk_o`.
- R10: In master mode, the codes are adopted only at an `lrc_o` rising edge, and the running frame keeps its old ratios. In slave mode, the codes are adopted every cycle.
- R11: After `mode_master` rises, the first `lrc_o` rising edge comes exactly one frame period of ticks later. The count starts with the first cycle in master mode.
- R12: Reset clears `bclk_o`, `lrc_o` and `cfg_err`. The adopted codes reset to 000 (bit clock) and 010 (frame scale).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_master | input | 1 | 1 = generate and drive the audio clocks, 0 = leave them undriven |
| bclk_div_code | input | 3 | Bit-clock ratio code |
| frame_scale_code | input | 3 | Frame-length scaling code |
| src_pll_sel | input | 1 | System tick source: 1 = PLL stream, 0 = external stream |
| ext_tick | input | 1 | External master clock tick enable |
| pll_tick | input | 1 | PLL output tick enable |
| bclk_o | output | 1 | Bit clock |
| bclk_oe | output | 1 | Output enable for the bit clock |
| lrc_o | output | 1 | Left/right frame clock |
| lrc_oe | output | 1 | Output enable for the frame clock |
| cfg_err | output | 1 | Sticky flag: a reserved bit-clock code was adopted |

## Verification
Both clock outputs come from registers loaded on the selected tick, so they change one cycle after the tick they answer. The output enables follow the mode input in the same cycle. The bench drives inputs on falling edges, samples outputs on falling edges, and measures every period as a count of falling edges between two observed transitions, which makes each count exact. The first frame clock edge after master entry is due on the frame-length-th falling edge after the mode input rises. A code written mid-frame shows up only in the frame after the next rising edge, and the bench checks both the old frame and the new one against these due times.

// File: rtl/aud_clkgen_pkg.sv
package aud_clkgen_pkg;

    typedef logic [2:0] code_t;

    typedef struct packed {
        code_t bdiv;
        code_t scale;
    } clk_cfg_t;

    // Bit-clock code to log2 of the ratio; reserved codes fall back to the largest ratio.
    function automatic logic [2:0] bclk_shift(input code_t c);
        case (c)
            3'd0:    bclk_shift = 3'd0;
            3'd1:    bclk_shift = 3'd1;
            3'd2:    bclk_shift = 3'd2;
            3'd3:    bclk_shift = 3'd3;
            3'd4:    bclk_shift = 3'd4;
            default: bclk_shift = 3'd5;
        endcase
    endfunction

    function automatic logic bclk_code_reserved(input code_t c);
        bclk_code_reserved = (c == 3'd6) || (c == 3'd7);
    endfunction

endpackage

// File: rtl/aud_clkgen_tick_sel.sv
module aud_clkgen_tick_sel (
    input  logic ext_tick,
    input  logic pll_tick,
    input  logic src_pll_sel,
    output logic sys_tick
);
    always_comb begin
        sys_tick = src_pll_sel ? pll_tick : ext_tick;
    end
endmodule

// File: rtl/aud_clkgen_frame_ctr.sv
module aud_clkgen_frame_ctr #(
    parameter int FRAME_BASE = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       tick,
    input  logic [2:0] scale_code,
    output logic       wrap,
    output logic       lrc
);
    localparam int MAX_LEN = FRAME_BASE * 12;
    localparam int POS_W   = $clog2(MAX_LEN);
    localparam int LEN_W   = POS_W + 1;
    localparam logic [LEN_W-1:0] LEN_X2 = LEN_W'(FRAME_BASE);
    localparam logic [LEN_W-1:0] LEN_X3 = LEN_W'(FRAME_BASE * 3 / 2);

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic             started;
        logic             lrc;
    } frm_st_t;

    frm_st_t          st_d, st_q;
    logic [LEN_W-1:0] len;
    logic [LEN_W-1:0] half;
    logic             wrap_c;

    // Length = (2 or 3) * FRAME_BASE/2, doubled per step of the upper code bits.
    always_comb begin
        len    = (scale_code[0] ? LEN_X3 : LEN_X2) << scale_code[2:1];
        half   = len >> 1;
        wrap_c = run && tick && ({1'b0, st_q.pos} == (len - 1'b1));

        st_d = st_q;
        if (!run) begin
            st_d = '0;
        end else if (tick) begin
            if (wrap_c) begin
                st_d.pos     = '0;
                st_d.started = 1'b1;
                st_d.lrc     = 1'b1;
            end else begin
                st_d.pos = st_q.pos + 1'b1;
                st_d.lrc = st_q.started && ({1'b0, st_d.pos} < half);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wrap = wrap_c;
    assign lrc  = st_q.lrc;
endmodule

// File: rtl/aud_clkgen_bclk_gen.sv
module aud_clkgen_bclk_gen #(
    parameter int MAX_SHIFT = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       tick,
    input  logic       restart,
    input  logic [2:0] shift,
    output logic       bclk
);
    localparam int CNT_W = MAX_SHIFT;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             bclk;
    } bck_st_t;

    bck_st_t          st_d, st_q;
    logic [CNT_W:0]   ratio;
    logic [CNT_W-1:0] full_m;
    logic [CNT_W-1:0] half_m;

    always_comb begin
        ratio  = (CNT_W + 1)'(1) << shift;
        full_m = CNT_W'(ratio - 1'b1);
        half_m = CNT_W'(ratio >> 1);

        st_d = st_q;
        if (!run) begin
            st_d = '0;
        end else if (shift == 3'd0) begin
            // Ratio one: the bit clock follows the tick stream itself.
            st_d.cnt  = '0;
            st_d.bclk = tick;
        end else if (tick) begin
            st_d.cnt  = restart ? '0 : ((st_q.cnt + 1'b1) & full_m);
            st_d.bclk = (st_d.cnt & half_m) != '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bclk = st_q.bclk;
endmodule

// File: rtl/aud_clkgen.sv
module aud_clkgen #(
    parameter int FRAME_BASE     = 128,
    parameter int BCLK_MAX_SHIFT = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_master,
    input  logic [2:0] bclk_div_code,
    input  logic [2:0] frame_scale_code,
    input  logic       src_pll_sel,
    input  logic       ext_tick,
    input  logic       pll_tick,
    output logic       bclk_o,
    output logic       bclk_oe,
    output logic       lrc_o,
    output logic       lrc_oe,
    output logic       cfg_err
);
    import aud_clkgen_pkg::*;

    localparam clk_cfg_t CFG_RST = '{bdiv: 3'b000, scale: 3'b010};

    typedef struct packed {
        clk_cfg_t act;
        logic     err;
    } top_st_t;

    top_st_t    st_d, st_q;
    logic       sys_tick;
    logic       frm_wrap;
    logic [2:0] shift_nxt;
    logic [2:0] act_bdiv;
    logic [2:0] act_scale;

    aud_clkgen_tick_sel u_tick_sel (
        .ext_tick    (ext_tick),
        .pll_tick    (pll_tick),
        .src_pll_sel (src_pll_sel),
        .sys_tick    (sys_tick)
    );

    // Codes are taken continuously while idle, and only at frame start while running.
    always_comb begin
        st_d = st_q;
        if (!mode_master || frm_wrap) begin
            st_d.act.bdiv  = bclk_div_code;
            st_d.act.scale = frame_scale_code;
            if (bclk_code_reserved(bclk_div_code)) st_d.err = 1'b1;
        end
        shift_nxt = bclk_shift(st_d.act.bdiv);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{act: CFG_RST, err: 1'b0};
        else        st_q <= st_d;
    end

    aud_clkgen_frame_ctr #(
        .FRAME_BASE (FRAME_BASE)
    ) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (mode_master),
        .tick       (sys_tick),
        .scale_code (st_q.act.scale),
        .wrap       (frm_wrap),
        .lrc        (lrc_o)
    );

    aud_clkgen_bclk_gen #(
        .MAX_SHIFT (BCLK_MAX_SHIFT)
    ) u_bclk (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (mode_master),
        .tick    (sys_tick),
        .restart (frm_wrap),
        .shift   (shift_nxt),
        .bclk    (bclk_o)
    );

    assign act_bdiv  = st_q.act.bdiv;
    assign act_scale = st_q.act.scale;
    assign bclk_oe   = mode_master;
    assign lrc_oe    = mode_master;
    assign cfg_err   = st_q.err;
endmodule

// File: rtl/aud_clkgen_chk.sv
module aud_clkgen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mode_master,
    input logic       src_pll_sel,
    input logic       ext_tick,
    input logic       pll_tick,
    input logic       bclk_o,
    input logic       lrc_o,
    input logic       cfg_err,
    input logic [2:0] act_bdiv,
    input logic [2:0] act_scale
);
    logic sel_tick;
    assign sel_tick = src_pll_sel ? pll_tick : ext_tick;

    AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_master |=> (!bclk_o && !lrc_o)); // R2

    AST_NO_TICK_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_master && !sel_tick) |=> $stable(lrc_o)); // R1

    AST_RSV_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (act_bdiv[2:1] == 2'b11) |-> cfg_err); // R5

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err); // R6

    AST_LRC_ON_BCLK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_master && $changed(lrc_o) && act_bdiv != 3'd0) |-> !bclk_o); // R9

    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_master && $past(mode_master) && !$rose(lrc_o))
            |-> ($stable(act_bdiv) && $stable(act_scale))); // R10
endmodule

bind aud_clkgen aud_clkgen_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_master (mode_master),
    .src_pll_sel (src_pll_sel),
    .ext_tick    (ext_tick),
    .pll_tick    (pll_tick),
    .bclk_o      (bclk_o),
    .lrc_o       (lrc_o),
    .cfg_err     (cfg_err),
    .act_bdiv    (act_bdiv),
    .act_scale   (act_scale)
);

// File: tb/aud_clkgen_bench.sv
module aud_clkgen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_master = 1'b0;
    logic [2:0] bclk_div_code = 3'd0;
    logic [2:0] frame_scale_code = 3'd2;
    logic       src_pll_sel = 1'b1;
    logic       ext_tick = 1'b0;
    logic       pll_tick = 1'b1;
    logic       bclk_o, bclk_oe, lrc_o, lrc_oe, cfg_err;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    int ext_ph  = 0;

    always #5 clk = ~clk;

    aud_clkgen u_aud_clkgen (
        .clk              (clk),
        .rst_n            (rst_n),
        .mode_master      (mode_master),
        .bclk_div_code    (bclk_div_code),
        .frame_scale_code (frame_scale_code),
        .src_pll_sel      (src_pll_sel),
        .ext_tick         (ext_tick),
        .pll_tick         (pll_tick),
        .bclk_o           (bclk_o),
        .bclk_oe          (bclk_oe),
        .lrc_o            (lrc_o),
        .lrc_oe           (lrc_oe),
        .cfg_err          (cfg_err)
    );

    // External tick: one in every three cycles.
    always @(negedge clk) begin
        ext_ph   <= (ext_ph == 2) ? 0 : ext_ph + 1;
        ext_tick <= (ext_ph == 2);
    end

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected below 190000", cyc);
            summary();
        end
    end

    task automatic chk_eq(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Counts falling edges until the chosen output shows the chosen transition.
    task automatic wait_edge(input bit use_lrc, input bit rising, output int n, output bit bclk_before);
        logic prev, cur, pb;
        bit   done;
        prev = use_lrc ? lrc_o : bclk_o;
        pb   = bclk_o;
        n    = 0;
        done = 0;
        bclk_before = 0;
        while (!done) begin
            @(negedge clk);
            n++;
            cur = use_lrc ? lrc_o : bclk_o;
            if (cur == rising && prev != rising) begin
                bclk_before = pb;
                done = 1;
            end else if (n > 20000) begin
                chk_eq("edge wait timeout", n, 0);
                done = 1;
            end
            prev = cur;
            pb   = bclk_o;
        end
    endtask

    // {src, bdiv, scale, frame ticks, bclk ratio, tick interval}
    localparam logic [25:0] VEC [0:7] = '{
        {1'b1, 3'd0, 3'd2, 11'd256,  6'd1,  2'd1},
        {1'b1, 3'd1, 3'd0, 11'd128,  6'd2,  2'd1},
        {1'b0, 3'd2, 3'd1, 11'd192,  6'd4,  2'd3},
        {1'b1, 3'd3, 3'd3, 11'd384,  6'd8,  2'd1},
        {1'b0, 3'd4, 3'd5, 11'd768,  6'd16, 2'd3},
        {1'b1, 3'd5, 3'd7, 11'd1536, 6'd32, 2'd1},
        {1'b1, 3'd4, 3'd4, 11'd512,  6'd16, 2'd1},
        {1'b0, 3'd2, 3'd6, 11'd1024, 6'd4,  2'd3}
    };

    initial begin
        int  n, n2;
        bit  bb;
        logic [25:0] v;
        int  fl, nr, iv;

        // R12: reset state
        repeat (3) @(negedge clk);
        chk_eq("R12 bclk_o in reset", int'(bclk_o), 0);
        chk_eq("R12 lrc_o in reset", int'(lrc_o), 0);
        chk_eq("R12 cfg_err in reset", int'(cfg_err), 0);
        chk_eq("R2 enables low in slave", int'(bclk_oe | lrc_oe), 0);
        rst_n = 1'b1;

        for (int i = 0; i < 8; i++) begin
            v  = VEC[i];
            fl = int'(v[18:8]);
            nr = int'(v[7:2]);
            iv = int'(v[1:0]);
            @(negedge clk);
            mode_master      = 1'b0;
            src_pll_sel      = v[25];
            bclk_div_code    = v[24:22];
            frame_scale_code = v[21:19];
            repeat (4) @(negedge clk);
            mode_master = 1'b1;
            #1;
            chk_eq("R3 both enables in master", int'(bclk_oe & lrc_oe), 1);
            wait_edge(1, 1, n, bb);
            wait_edge(1, 0, n, bb);
            chk_eq("R8 lrc high half", n, fl * iv / 2);
            wait_edge(1, 1, n2, bb);
            chk_eq("R7 R1 lrc period", n + n2, fl * iv);
            if (nr > 1) begin
                chk_eq("R9 bclk falls at lrc rise", int'({bb, bclk_o}), 2);
                wait_edge(0, 1, n, bb);
                wait_edge(0, 1, n, bb);
                chk_eq("R4 R1 bclk period", n, nr * iv);
            end else begin
                chk_eq("R4 ratio one bclk level", int'(bclk_o), 1);
            end
        end

        // R11: first frame edge after master entry
        @(negedge clk);
        mode_master = 1'b0;
        src_pll_sel = 1'b1;
        bclk_div_code = 3'd1;
        frame_scale_code = 3'd0;
        repeat (3) @(negedge clk);
        mode_master = 1'b1;
        wait_edge(1, 1, n, bb);
        chk_eq("R11 first lrc rise delay", n, 128);

        // R10: mid-frame code change waits for the next frame
        wait_edge(1, 1, n, bb);
        bclk_div_code = 3'd5;
        frame_scale_code = 3'd7;
        wait_edge(1, 0, n, bb);
        chk_eq("R10 old frame half kept", n, 64);
        wait_edge(0, 1, n, bb);
        wait_edge(0, 1, n, bb);
        chk_eq("R10 old bclk ratio kept", n, 2);
        wait_edge(1, 1, n, bb);
        wait_edge(1, 0, n, bb);
        wait_edge(1, 1, n2, bb);
        chk_eq("R10 new frame period", n + n2, 1536);
        wait_edge(0, 1, n, bb);
        wait_edge(0, 1, n, bb);
        chk_eq("R10 new bclk ratio", n, 32);

        // R5 R6: reserved code
        @(negedge clk);
        mode_master = 1'b0;
        bclk_div_code = 3'd6;
        frame_scale_code = 3'd0;
        repeat (3) @(negedge clk);
        chk_eq("R6 flag on reserved code", int'(cfg_err), 1);
        mode_master = 1'b1;
        wait_edge(0, 1, n, bb);
        wait_edge(0, 1, n, bb);
        chk_eq("R5 reserved acts as 32", n, 32);
        @(negedge clk);
        bclk_div_code = 3'd0;
        mode_master = 1'b0;
        repeat (5) @(negedge clk);
        chk_eq("R6 flag sticky", int'(cfg_err), 1);

        // R2: slave mode stays quiet while ticks run
        mode_master = 1'b1;
        bclk_div_code = 3'd1;
        repeat (50) @(negedge clk);
        mode_master = 1'b0;
        n = 0;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (bclk_o || lrc_o || bclk_oe || lrc_oe) n++;
        end
        chk_eq("R2 slave outputs quiet", n, 0);

        // R12: reset clears the sticky flag
        rst_n = 1'b0;
        @(negedge clk);
        chk_eq("R12 reset clears cfg_err", int'(cfg_err), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        summary();
    end
endmodule